// File: doc/BRIEF.md
# Pipelined Quadratic Polynomial Evaluator

This block evaluates a second-degree polynomial c2·x² + c1·x + c0 on signed fixed-point operands. It accepts a new operand set on every clock cycle, with a one-bit valid strobe. After a fixed number of cycles it returns the exact result, with a matching valid strobe. Inside, two branches run at the same time. The first branch squares x in a dedicated squarer and then scales the square by c2. The second branch multiplies x by c1 and adds c0. A final adder joins the two branch results.

The latency of the squarer, the multiplier and the adder is set by parameters. The block works out the depth of each branch and pads the shallower branch with exactly the missing number of registers. It also delays each coefficient until the cycle in which its partner operand reaches it. An integrator can therefore retune the sub-unit latencies to meet a clock target without touching the alignment logic. No intermediate width is truncated: the square is 2W bits wide, each product is 3W bits wide, and the result carries one guard bit on top.

Top module: `quad_poly_eval`

## Requirements
- R1: Inputs `in_x`, `coef_sq`, `coef_lin` and `coef_const` are W-bit signed two's complement values. `y` is the exact value coef_sq·in_x² + coef_lin·in_x + coef_const, as a signed (3W+1)-bit number.
- R2: Define LAT = max(SQ_LAT+MUL_LAT, MUL_LAT+ADD_LAT) + ADD_LAT + 1. An operand set captured with `in_valid` high at rising edge n produces `out_valid` high, and its result on `y`, right after edge n+LAT-1. `out_valid` is high in no other cycle.
- R3: Operand sets can be presented on every consecutive cycle. The results come out on consecutive cycles, in the order the sets went in, and no set interferes with another.
- R4: While `out_valid` is low, `y` keeps the last result it showed. Input values presented with `in_valid` low have no effect on `y`.
- R5: While `rst_n` is low, `out_valid` is 0 and `y` is 0.
- R6: The extreme operands are computed without loss. This covers x = -2^(W-1) together with all-negative or mixed-sign extreme coefficients, and all-maximum positive values.
- R7: The latency in R2 holds for every latency setting where each of SQ_LAT, MUL_LAT and ADD_LAT is at least 1. This includes a deeper square branch, a deeper linear branch, and equal branch depths (no padding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the strobe and result |
| in_valid | input | 1 | Operand set present this cycle |
| in_x | input | W | Signed variable x |
| coef_sq | input | W | Signed coefficient of x² |
| coef_lin | input | W | Signed coefficient of x |
| coef_const | input | W | Signed constant term |
| out_valid | output | 1 | Result on `y` is new this cycle |
| y | output | 3W+1 | Signed polynomial value |

## Verification
The embedded properties watch the strobe bookkeeping on every cycle. The count of operand sets in flight never exceeds the latency. No valid output appears after a quiet period of LAT cycles. Every valid output has a set in flight to account for it. The result holds steady between valid outputs. What the properties cannot show is whether the two branches actually meet on the same operand set and whether the value is arithmetically right. Only the bench can show that. It runs three latency settings side by side (square branch deeper, linear branch deeper, equal depths) and compares every output against a reference polynomial computed per captured cycle, using extreme operands and idle gaps filled with junk.

// File: rtl/quad_poly_eval.sv
module qp_pipe #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [DEPTH];
  always_ff @(posedge clk) begin
    st[0] <= d;
    for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
  end
  assign q = st[DEPTH-1];
endmodule

module quad_poly_eval #(
  parameter int W       = 16,
  parameter int SQ_LAT  = 2,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_x,
  input  logic [W-1:0]   coef_sq,
  input  logic [W-1:0]   coef_lin,
  input  logic [W-1:0]   coef_const,
  output logic           out_valid,
  output logic [3*W:0]   y
);
  localparam int PW   = 2 * W;
  localparam int QW   = 3 * W;
  localparam int RW   = 3 * W + 1;
  localparam int DA   = SQ_LAT + MUL_LAT;
  localparam int DB   = MUL_LAT + ADD_LAT;
  localparam int DMAX = (DA > DB) ? DA : DB;
  localparam int PADA = DMAX - DA;
  localparam int PADB = DMAX - DB;
  localparam int LAT  = DMAX + ADD_LAT + 1;
  localparam int CW   = $clog2(LAT + 1) + 1;

  logic [PW-1:0] x_ext;
  assign x_ext = {{W{in_x[W-1]}}, in_x};

  // square branch
  logic [PW-1:0] sq_c, sq_q;
  logic [W-1:0]  c2_d;
  logic [QW-1:0] pa_c, pa_q, pa_al;
  assign sq_c = $signed(x_ext) * $signed(x_ext);
  qp_pipe #(.WIDTH(PW), .DEPTH(SQ_LAT)) u_sq (.clk(clk), .d(sq_c),    .q(sq_q));
  qp_pipe #(.WIDTH(W),  .DEPTH(SQ_LAT)) u_c2 (.clk(clk), .d(coef_sq), .q(c2_d));
  assign pa_c = $signed({{W{sq_q[PW-1]}}, sq_q}) * $signed({{PW{c2_d[W-1]}}, c2_d});
  qp_pipe #(.WIDTH(QW), .DEPTH(MUL_LAT)) u_pa (.clk(clk), .d(pa_c), .q(pa_q));

  // linear branch
  logic [PW-1:0] pb_c, pb_q;
  logic [W-1:0]  c0_d;
  logic [QW-1:0] sb_c, sb_q, sb_al;
  assign pb_c = $signed(x_ext) * $signed({{W{coef_lin[W-1]}}, coef_lin});
  qp_pipe #(.WIDTH(PW), .DEPTH(MUL_LAT)) u_pb (.clk(clk), .d(pb_c),       .q(pb_q));
  qp_pipe #(.WIDTH(W),  .DEPTH(MUL_LAT)) u_c0 (.clk(clk), .d(coef_const), .q(c0_d));
  assign sb_c = {{W{pb_q[PW-1]}}, pb_q} + {{PW{c0_d[W-1]}}, c0_d};
  qp_pipe #(.WIDTH(QW), .DEPTH(ADD_LAT)) u_sb (.clk(clk), .d(sb_c), .q(sb_q));

  // depth balancing
  generate
    if (PADA == 0) begin : g_nopad_a
      assign pa_al = pa_q;
    end else begin : g_pad_a
      qp_pipe #(.WIDTH(QW), .DEPTH(PADA)) u_pad_a (.clk(clk), .d(pa_q), .q(pa_al));
    end
    if (PADB == 0) begin : g_nopad_b
      assign sb_al = sb_q;
    end else begin : g_pad_b
      qp_pipe #(.WIDTH(QW), .DEPTH(PADB)) u_pad_b (.clk(clk), .d(sb_q), .q(sb_al));
    end
  endgenerate

  // join
  logic [RW-1:0] fn_c, fn_q;
  assign fn_c = {pa_al[QW-1], pa_al} + {sb_al[QW-1], sb_al};
  qp_pipe #(.WIDTH(RW), .DEPTH(ADD_LAT)) u_fn (.clk(clk), .d(fn_c), .q(fn_q));

  logic [LAT-1:0] vld_sr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr <= '0;
      y      <= '0;
    end else begin
      vld_sr <= {vld_sr[LAT-2:0], in_valid};
      if (vld_sr[LAT-2]) y <= fn_q;
    end
  end
  assign out_valid = vld_sr[LAT-1];

  logic [CW-1:0] inflight, quiet;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      quiet    <= CW'(LAT);
    end else begin
      inflight <= inflight + CW'(in_valid) - CW'(out_valid);
      if (in_valid)               quiet <= '0;
      else if (quiet < CW'(LAT))  quiet <= quiet + 1'b1;
    end
  end

  // R4
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(y));
  // R3
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));
  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= CW'(LAT)) |-> !out_valid);
  // R2
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != '0));
endmodule

// File: tb/quad_poly_eval_tb_top.sv
module quad_poly_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int YW = 3 * W + 1;
  localparam int HN = 4096;

  // three latency settings: square branch deeper, linear branch deeper, equal
  localparam int LAT0 = 5 + 1 + 1;
  localparam int LAT1 = 5 + 3 + 1;
  localparam int LAT2 = 4 + 2 + 1;

  localparam logic [31:0] VEC [16] = '{
    32'h03020507, 32'hFD020507, 32'h007F8011, 32'h7F010100,
    32'h80010000, 32'h10FF20F0, 32'hC4339A01, 32'h01010101,
    32'hFFFFFFFF, 32'h55AA55AA, 32'h2BE74C90, 32'h9E127F80,
    32'h0840C03F, 32'hE07F7F7F, 32'h649C649C, 32'h00000080};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_x = '0, c2 = '0, c1 = '0, c0 = '0;
  logic ov0, ov1, ov2;
  logic [YW-1:0] y0, y1, y2;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_poly_eval #(.W(W), .SQ_LAT(2), .MUL_LAT(3), .ADD_LAT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .coef_sq(c2), .coef_lin(c1), .coef_const(c0), .out_valid(ov0), .y(y0));
  quad_poly_eval #(.W(W), .SQ_LAT(1), .MUL_LAT(2), .ADD_LAT(3)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .coef_sq(c2), .coef_lin(c1), .coef_const(c0), .out_valid(ov1), .y(y1));
  quad_poly_eval #(.W(W), .SQ_LAT(2), .MUL_LAT(2), .ADD_LAT(2)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .coef_sq(c2), .coef_lin(c1), .coef_const(c0), .out_valid(ov2), .y(y2));

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit hv [HN];
  longint hexp [HN];
  string hreq [HN];
  string cur_req = "R1";
  longint last [3];
  bit done = 1'b0;

  always @(posedge clk) begin
    longint xv, a2, a1, a0;
    cyc = cyc + 1;
    xv = longint'(signed'(in_x));
    a2 = longint'(signed'(c2));
    a1 = longint'(signed'(c1));
    a0 = longint'(signed'(c0));
    hv[cyc]   = in_valid;
    hexp[cyc] = a2 * xv * xv + a1 * xv + a0;
    hreq[cyc] = cur_req;
  end

  task automatic chk(input int k, input logic ov, input logic [YW-1:0] yv, input int lat);
    int idx;
    logic ev;
    string rq;
    longint got;
    idx = cyc - lat + 1;
    ev = (idx >= 1) && hv[idx];
    rq = (k == 2) ? "R7" : "R2";
    checks++;
    if (ov !== ev) begin
      errs++;
      $display("FAIL %s dut%0d cycle %0d out_valid actual=%b expected=%b", rq, k, cyc, ov, ev);
    end
    if (ev) last[k] = hexp[idx];
    got = longint'(signed'(yv));
    checks++;
    if (got != last[k]) begin
      errs++;
      $display("FAIL %s dut%0d cycle %0d y actual=%0d expected=%0d",
               ev ? hreq[idx] : "R4", k, cyc, got, last[k]);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(0, ov0, y0, LAT0);
      chk(1, ov1, y1, LAT1);
      chk(2, ov2, y2, LAT2);
    end
  end

  task automatic drive(input logic v, input logic [31:0] w, input string rq);
    @(negedge clk);
    in_valid = v;
    in_x = w[31:24]; c2 = w[23:16]; c1 = w[15:8]; c0 = w[7:0];
    cur_req = rq;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 3; k++) last[k] = 0;
    repeat (3) @(negedge clk);
    // R5: outputs cleared under reset
    checks++;
    if (ov0 !== 1'b0 || ov1 !== 1'b0 || ov2 !== 1'b0 || y0 !== '0 || y1 !== '0 || y2 !== '0) begin
      errs++;
      $display("FAIL R5 reset state actual=%b%b%b/%0d expected=000/0", ov0, ov1, ov2, y0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1, R3: table walked back to back
    for (int i = 0; i < 16; i++) drive(1'b1, VEC[i], "R3");
    // R4: junk on inputs with valid low
    for (int i = 0; i < 14; i++) drive(1'b0, 32'hA5C3_7E19 ^ (i * 32'h0101_0101), "R4");
    // R6: extremes
    drive(1'b1, 32'h80808080, "R6");
    drive(1'b1, 32'h7F7F7F7F, "R6");
    drive(1'b1, 32'h807F807F, "R6");
    drive(1'b1, 32'h8080_7F80, "R6");
    drive(1'b0, 32'hFFFFFFFF, "R4");
    // R1: isolated sets with gaps
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, VEC[i*2+1] ^ 32'h1357_9BDF, "R1");
      drive(1'b0, 32'h0, "R4");
      drive(1'b0, VEC[i], "R4");
    end
    repeat (20) drive(1'b0, 32'h5A5A5A5A, "R4");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (3000) @(posedge clk);
    done = 1'b1;
    checks++;
    errs++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
  end
endmodule